// File: doc/BRIEF.md
# Serial Tuner Control Sequencer

The sequencer plays a short table of control/data entries onto a bit-banged tuner port. The port has a serial clock, a serial data line and two active-high select lines. Software first loads up to sixteen entries through a simple write port. Each entry holds a data byte and a four-bit control field. The control field chooses a long (8-bit) or short (3-bit) shift, can keep the serial clock quiet for the whole entry, and can raise either select line or both while that entry plays.

With these choices one stream can carry the synthesizer programming words and the latch strobes between them. Programming words are clocked entries with no select. Latch strobes are short, clock-less entries that raise a select.

A start strobe latches the number of entries to play. The port then stays in its quiet state for a set number of system cycles. The entries follow in index order, and a one-cycle done pulse ends the sequence. The bit period and the length of the quiet lead-in are counts of system clock cycles, set by parameters.

Top module: `tuner_wire_seq`

## Requirements
- R1: While reset is held and after it is released, ser_clk, ser_data, sel0, sel1, busy and done are all low.
- R2: A write with wr_en high stores wr_data and wr_ctrl in the slot given by wr_idx. In wr_ctrl, bit 0 selects a 3-bit shift (0 means 8 bits), bit 1 keeps the clock low for the entry, bit 2 raises sel0 and bit 3 raises sel1.
- R3: start in the idle state latches seq_len and plays slots 0 to seq_len-1 in ascending order. A start or a new seq_len seen while busy is high changes nothing.
- R4: After start, busy rises. For INIT_CYC cycles all four port lines stay low before the first entry begins.
- R5: An 8-bit entry puts data bits 7 down to 0 on ser_data, MSB first. A 3-bit entry puts bits 7, 6 and 5 on the line, in that order.
- R6: Each bit lasts 2*HALF_CYC cycles: HALF_CYC cycles with ser_clk low, then HALF_CYC cycles with ser_clk high. ser_data changes only while ser_clk is low, so it is stable across every rising edge.
- R7: An entry with the clock-off bit keeps ser_clk low for its whole length. It still presents its data bits with the normal bit timing.
- R8: sel0 and sel1 follow the select bits of the entry now playing, for exactly that entry's length, and are low at all other times.
- R9: done is high for exactly one cycle, in the cycle after the last entry ends. busy falls in the cycle after done.
- R10: A seq_len of 0 gives a done pulse in the cycle after start with no port activity. A seq_len above ENTRIES plays exactly ENTRIES slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the entry table |
| wr_idx | input | IDX_W (4) | Slot written |
| wr_data | input | 8 | Data byte of the entry |
| wr_ctrl | input | 4 | Control field: short, clock-off, sel0, sel1 |
| seq_len | input | LEN_W (5) | Number of entries to play, latched at start |
| start | input | 1 | Begins playback when idle |
| ser_clk | output | 1 | Serial clock to the tuner |
| ser_data | output | 1 | Serial data to the tuner |
| sel0 | output | 1 | Select line 0, active high |
| sel1 | output | 1 | Select line 1, active high |
| busy | output | 1 | High from start until the done pulse ends |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with sixteen entries, HALF_CYC of 3 and INIT_CYC of 5. A full sixteen-entry stream of long and short entries therefore finishes in under a thousand cycles, so the bench can replay many complete tables. A half period longer than one cycle makes the low and high phases visibly distinct, which exposes misplaced data changes and edge-count errors. The short lead-in still separates the quiet interval from the first bit. The bench also covers the clamped and zero lengths and a start pulse arriving in the middle of a sequence.

// File: rtl/tws_pkg.sv
package tws_pkg;

   localparam int BYTE_W     = 8;
   localparam int LONG_BITS  = 8;
   localparam int SHORT_BITS = 3;
   localparam int BITS_W     = $clog2(LONG_BITS + 1);

   typedef struct packed {
      logic sel1;
      logic sel0;
      logic no_clk;
      logic short3;
   } ctrl_t;

   typedef struct packed {
      ctrl_t             ctrl;
      logic [BYTE_W-1:0] data;
   } entry_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_INIT = 2'd1,
      S_RUN  = 2'd2,
      S_DONE = 2'd3
   } seq_state_t;

endpackage

// File: rtl/tws_store.sv
module tws_store
   import tws_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  entry_t           wr_entry,
   input  logic [IDX_W-1:0] rd_idx,
   output entry_t           rd_entry
);

   entry_t slots [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      entry_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            slot_q <= wr_entry;
      end
      assign slots[i] = slot_q;
   end

   always_comb begin
      rd_entry = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (rd_idx == IDX_W'(i))
            rd_entry = slots[i];
   end

endmodule

// File: rtl/tws_clkgen.sv
module tws_clkgen #(
   parameter int HALF_CYC = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic phase,
   output logic bit_end
);

   logic half_end;

   if (HALF_CYC == 1) begin : g_fast
      assign half_end = run;
   end else begin : g_count
      localparam int HALF_W = $clog2(HALF_CYC);
      logic [HALF_W-1:0] hcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hcnt <= '0;
         else if (!run || hcnt == HALF_W'(HALF_CYC - 1))
            hcnt <= '0;
         else
            hcnt <= hcnt + 1'b1;
      end
      assign half_end = run && (hcnt == HALF_W'(HALF_CYC - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= 1'b0;
      else if (!run)
         phase <= 1'b0;
      else if (half_end)
         phase <= ~phase;
   end

   assign bit_end = half_end && phase;

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter
   import tws_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] ld_data,
   input  logic              ld_short,
   input  logic              advance,
   output logic              bit_out,
   output logic              last_bit
);

   logic [BYTE_W-1:0] sr;
   logic [BITS_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         left <= '0;
      end else if (load) begin
         sr   <= ld_data;
         left <= ld_short ? BITS_W'(SHORT_BITS) : BITS_W'(LONG_BITS);
      end else if (advance) begin
         sr   <= {sr[BYTE_W-2:0], 1'b0};
         left <= (left != '0) ? left - 1'b1 : left;
      end
   end

   assign bit_out  = sr[BYTE_W-1];
   assign last_bit = (left == BITS_W'(1));

endmodule

// File: rtl/tuner_wire_seq.sv
module tuner_wire_seq
   import tws_pkg::*;
#(
   parameter int ENTRIES  = 16,
   parameter int HALF_CYC = 25,
   parameter int INIT_CYC = 834,
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int LEN_W   = $clog2(ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [3:0]       wr_ctrl,
   input  logic [LEN_W-1:0] seq_len,
   input  logic             start,
   output logic             ser_clk,
   output logic             ser_data,
   output logic             sel0,
   output logic             sel1,
   output logic             busy,
   output logic             done
);

   localparam int INIT_W = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;

   if (ENTRIES < 1) begin : g_bad_entries
      $error("tuner_wire_seq: ENTRIES must be at least 1");
   end
   if (HALF_CYC < 1) begin : g_bad_half
      $error("tuner_wire_seq: HALF_CYC must be at least 1");
   end
   if (INIT_CYC < 1) begin : g_bad_init
      $error("tuner_wire_seq: INIT_CYC must be at least 1");
   end

   seq_state_t        state;
   logic [LEN_W-1:0]  len_q;
   logic [IDX_W-1:0]  idx;
   logic [INIT_W-1:0] init_cnt;
   ctrl_t             cur_ctrl;

   logic [LEN_W-1:0]  len_clamped;
   logic [IDX_W-1:0]  rd_idx;
   entry_t            rd_entry;
   entry_t            wr_entry;
   logic              phase, bit_end;
   logic              bit_out, last_bit;
   logic              init_last, entry_end, seq_last, load;

   assign wr_entry.ctrl = ctrl_t'(wr_ctrl);
   assign wr_entry.data = wr_data;

   assign len_clamped = (seq_len > LEN_W'(ENTRIES)) ? LEN_W'(ENTRIES) : seq_len;
   assign init_last   = (state == S_INIT) && (init_cnt == INIT_W'(INIT_CYC - 1));
   assign entry_end   = (state == S_RUN) && bit_end && last_bit;
   assign seq_last    = (LEN_W'(idx) == len_q - LEN_W'(1));
   assign load        = init_last || (entry_end && !seq_last);
   assign rd_idx      = (state == S_RUN) ? idx + 1'b1 : '0;

   tws_store #(.ENTRIES(ENTRIES)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_entry (wr_entry),
      .rd_idx   (rd_idx),
      .rd_entry (rd_entry)
   );

   tws_clkgen #(.HALF_CYC(HALF_CYC)) i_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == S_RUN),
      .phase   (phase),
      .bit_end (bit_end)
   );

   tws_shifter i_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .ld_data  (rd_entry.data),
      .ld_short (rd_entry.ctrl.short3),
      .advance  (bit_end && !load),
      .bit_out  (bit_out),
      .last_bit (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         len_q    <= '0;
         idx      <= '0;
         init_cnt <= '0;
         cur_ctrl <= '0;
      end else begin
         if (load)
            cur_ctrl <= rd_entry.ctrl;
         unique case (state)
            S_IDLE: if (start) begin
               len_q    <= len_clamped;
               idx      <= '0;
               init_cnt <= '0;
               state    <= (len_clamped == '0) ? S_DONE : S_INIT;
            end
            S_INIT: begin
               if (init_last)
                  state <= S_RUN;
               else
                  init_cnt <= init_cnt + 1'b1;
            end
            S_RUN: if (entry_end) begin
               if (seq_last)
                  state <= S_DONE;
               else
                  idx <= idx + 1'b1;
            end
            S_DONE: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign ser_clk  = (state == S_RUN) && phase && !cur_ctrl.no_clk;
   assign ser_data = (state == S_RUN) && bit_out;
   assign sel0     = (state == S_RUN) && cur_ctrl.sel0;
   assign sel1     = (state == S_RUN) && cur_ctrl.sel1;
   assign busy     = (state != S_IDLE);
   assign done     = (state == S_DONE);

endmodule

// File: rtl/tws_checker.sv
module tws_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic ser_clk,
   input logic ser_data,
   input logic sel0,
   input logic sel1,
   input logic busy,
   input logic done
);

   a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sel0 && !sel1 && !ser_clk && !ser_data));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_busy_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   a_r6_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_data) |-> !ser_clk);

   a_r3_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

endmodule

bind tuner_wire_seq tws_checker i_tws_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .ser_clk  (ser_clk),
   .ser_data (ser_data),
   .sel0     (sel0),
   .sel1     (sel1),
   .busy     (busy),
   .done     (done)
);

// File: tb/test_tuner_wire_seq.sv
`timescale 1ns/1ps
module test_tuner_wire_seq;

   localparam int ENTRIES = 16;
   localparam int HALF    = 3;
   localparam int INIT    = 5;
   localparam int IDX_W   = 4;
   localparam int LEN_W   = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0;
   logic [7:0]       wr_data = '0;
   logic [3:0]       wr_ctrl = '0;
   logic [LEN_W-1:0] seq_len = '0;
   logic             start = 1'b0;
   logic             ser_clk, ser_data, sel0, sel1, busy, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [7:0] e_data [ENTRIES];
   logic [3:0] e_ctrl [ENTRIES];

   always #2 clk = ~clk;

   tuner_wire_seq #(.ENTRIES(ENTRIES), .HALF_CYC(HALF), .INIT_CYC(INIT)) i_tuner_wire_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .wr_ctrl(wr_ctrl), .seq_len(seq_len), .start(start), .ser_clk(ser_clk),
      .ser_data(ser_data), .sel0(sel0), .sel1(sel1), .busy(busy), .done(done));

   // expected {busy, done, sel1, sel0, ser_clk, ser_data} k cycles after start
   function automatic logic [5:0] model(int k, int n);
      int t, nb, dur, bi;
      logic ph;
      if (n == 0) return (k == 1) ? 6'b110000 : 6'b000000;
      if (k <= INIT) return 6'b100000;
      t = k - INIT - 1;
      for (int i = 0; i < n; i++) begin
         nb  = e_ctrl[i][0] ? 3 : 8;
         dur = nb * 2 * HALF;
         if (t < dur) begin
            bi = t / (2 * HALF);
            ph = ((t % (2 * HALF)) >= HALF);
            return {1'b1, 1'b0, e_ctrl[i][3], e_ctrl[i][2], ph && !e_ctrl[i][1], e_data[i][7-bi]};
         end
         t -= dur;
      end
      if (t == 0) return 6'b110000;
      return 6'b000000;
   endfunction

   function automatic int seq_cycles(int n);
      int s = 0;
      for (int i = 0; i < n; i++) s += (e_ctrl[i][0] ? 3 : 8) * 2 * HALF;
      return s;
   endfunction

   task automatic write_entry(int i, logic [7:0] d, logic [3:0] c);
      wr_en = 1'b1; wr_idx = IDX_W'(i); wr_data = d; wr_ctrl = c;
      @(negedge clk);
      wr_en = 1'b0;
      e_data[i] = d; e_ctrl[i] = c;
   endtask

   task automatic check_field(string tag, string req, bit ok_all, int k, logic [5:0] g, logic [5:0] e);
      checks++;
      if (!ok_all) begin
         errors++;
         $display("FAIL %s %s at k=%0d got %b expected %b", tag, req, k, g, e);
      end
   endtask

   task automatic run_seq(int len, int glitch_k, string tag);
      int n, lim, bk_clk, bk_dat, bk_sel, bk_dn;
      logic [5:0] g, e, gc, ec, gd, ed, gs, es, gn, en;
      n   = (len > ENTRIES) ? ENTRIES : len;
      lim = INIT + seq_cycles(n) + 3;
      bk_clk = -1; bk_dat = -1; bk_sel = -1; bk_dn = -1;
      gc = '0; ec = '0; gd = '0; ed = '0; gs = '0; es = '0; gn = '0; en = '0;
      seq_len = LEN_W'(len); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= lim; k++) begin
         g = {busy, done, sel1, sel0, ser_clk, ser_data};
         e = model(k, n);
         if (g[1] !== e[1] && bk_clk < 0) begin bk_clk = k; gc = g; ec = e; end
         if (g[0] !== e[0] && bk_dat < 0) begin bk_dat = k; gd = g; ed = e; end
         if (g[3:2] !== e[3:2] && bk_sel < 0) begin bk_sel = k; gs = g; es = e; end
         if (g[5:4] !== e[5:4] && bk_dn < 0) begin bk_dn = k; gn = g; en = e; end
         if (k == glitch_k) begin start = 1'b1; seq_len = LEN_W'(1); end
         else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      check_field(tag, "R4 R6 R7 clock", bk_clk < 0, bk_clk, gc, ec);
      check_field(tag, "R5 data bits", bk_dat < 0, bk_dat, gd, ed);
      check_field(tag, "R8 selects", bk_sel < 0, bk_sel, gs, es);
      check_field(tag, "R9 R10 busy/done", bk_dn < 0, bk_dn, gn, en);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < ENTRIES; i++) begin e_data[i] = '0; e_ctrl[i] = '0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if ({ser_clk, ser_data, sel0, sel1, busy, done} !== 6'b0) begin
         errors++;
         $display("FAIL R1 in reset got %b expected 000000", {ser_clk, ser_data, sel0, sel1, busy, done});
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      checks++;
      if ({ser_clk, ser_data, sel0, sel1, busy, done} !== 6'b0) begin
         errors++;
         $display("FAIL R1 after reset got %b expected 000000", {ser_clk, ser_data, sel0, sel1, busy, done});
      end

      // R2: directed table of programming words and latch strobes
      write_entry(0,  8'h9c, 4'b0000);
      write_entry(1,  8'h04, 4'b0000);
      write_entry(2,  8'h20, 4'b0001);
      write_entry(3,  8'h40, 4'b0111);
      write_entry(4,  8'h5a, 4'b0000);
      write_entry(5,  8'hc3, 4'b0000);
      write_entry(6,  8'h80, 4'b0001);
      write_entry(7,  8'h40, 4'b0111);
      write_entry(8,  8'h80, 4'b0000);
      write_entry(9,  8'h10, 4'b0000);
      write_entry(10, 8'h20, 4'b0001);
      write_entry(11, 8'h40, 4'b1011);
      write_entry(12, 8'h2a, 4'b0000);
      write_entry(13, 8'h8e, 4'b0000);
      write_entry(14, 8'he0, 4'b0001);
      write_entry(15, 8'h40, 4'b1011);
      run_seq(16, -1, "R2 R3 full table");
      run_seq(4, -1, "R3 four entries");
      // R3: start while busy is ignored
      run_seq(6, INIT + 20, "R3 start while busy");
      // R10: empty and oversize lengths
      run_seq(0, -1, "R10 zero length");
      run_seq(25, -1, "R10 clamped length");
      // R7 R8: single clock-off strobe with both selects and an 8-bit length
      write_entry(0, 8'hff, 4'b1110);
      run_seq(1, -1, "R7 long clock-off strobe");
      // R5: 8-bit pattern with a clocked select
      write_entry(0, 8'h81, 4'b1000);
      run_seq(1, -1, "R5 R8 single long");

      // random tables
      for (int r = 0; r < 18; r++) begin
         for (int i = 0; i < ENTRIES; i++)
            write_entry(i, 8'($urandom), 4'($urandom));
         run_seq(1 + int'($urandom % ENTRIES), -1, "R5 R6 random");
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule